// File: doc/BRIEF.md
# 100 Mbps Link Status Monitor

This block decides whether a 100 Mbps receive path has a usable link. The link is declared up only after the descrambler has reported lock without a break for a long qualification time. After that, lock alone no longer holds the link. A rolling check does: somewhere in every supervision window the receiver must see a run of consecutive idle symbols. Short noise bursts that break lock for a moment therefore do not take the link down. Only a whole window without a clean idle run does.

When the link fails, the block raises a single-cycle interrupt and clears a latch-low status bit. If auto-negotiation is enabled, it also raises a renegotiation request. It gates outgoing packet transmission on the link state. A diagnostic override opens that gate while the link is down, but only when auto-negotiation is disabled. With auto-negotiation enabled and no link, the block asks for link pulse bursts instead.

All time windows are parameters counted in clock cycles, so short values can be used in simulation.

Top module: `link_qual_mon`

## Requirements
- R1: `link_o` rises after the edge at which `lock_i` has been sampled high on QUAL_CYC consecutive rising edges while the link was down. It stays low after only QUAL_CYC-1 such edges.
- R2: A single sampled low on `lock_i` during qualification restarts the count, and a full QUAL_CYC further samples are needed.
- R3: An idle symbol is an edge with `sym_vld_i`=1 and `sym_idle_i`=1. While the link is up, each run of RUN_LEN consecutive idle symbols restarts the supervision window, and a link fed such runs stays up indefinitely. A valid symbol with `sym_idle_i`=0 restarts the run count. Edges with `sym_vld_i`=0 neither add to nor break a run.
- R4: The link drops WIN_CYC edges after it came up (or after the last completed run) if no run completes in between. Runs of only RUN_LEN-1 idles do not count.
- R5: `loss_irq_o` is high for exactly the first cycle in which `link_o` is low after a drop. It stays low when the link comes up.
- R6: `rereq_o` pulses together with `loss_irq_o` only when `an_en_i` was high at the drop edge. Otherwise it stays low.
- R7: `link_stat_o` is 0 after reset and clears on link loss. It is set one cycle after `rd_stb_i` is sampled high while the link is up. A strobe while the link is down leaves it at 0.
- R8: `tx_allow_o` = `link_o` OR (`ovr_i` AND NOT `an_en_i`), combinationally.
- R9: `burst_req_o` = NOT `link_o` AND `an_en_i`, combinationally.
- R10: After a drop, the link comes back up only after a fresh full qualification of QUAL_CYC lock samples, counted from the drop edge.
- R11: In reset, `link_o`, `link_stat_o`, `loss_irq_o`, `rereq_o` and `tx_allow_o` (with `ovr_i`=0) are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Descrambler lock flag |
| sym_vld_i | input | 1 | One received symbol this cycle |
| sym_idle_i | input | 1 | The current symbol is idle |
| an_en_i | input | 1 | Auto-negotiation enabled |
| ovr_i | input | 1 | Link-failure override for transmit |
| rd_stb_i | input | 1 | Status read strobe; re-arms the latched bit |
| link_o | output | 1 | Live link status |
| link_stat_o | output | 1 | Latch-low link status |
| loss_irq_o | output | 1 | One-cycle pulse on link loss |
| rereq_o | output | 1 | One-cycle renegotiation request |
| burst_req_o | output | 1 | Request for link pulse bursts |
| tx_allow_o | output | 1 | Packet transmission permitted |

## Verification
The bench breaks lock one cycle short of qualification. A design that failed to restart its timer would bring the link up early. It feeds idle runs one symbol short of RUN_LEN and then runs of exactly RUN_LEN. A design that was off by one in the run length would either drop a healthy link or keep a noisy one. The exact drop edge is checked against the window length. After each drop, the re-qualification is timed again, which catches a qualifier that does not clear when the link is up. The interrupt, renegotiation and latch-low bit are checked on the exact cycle of loss. The transmit gate is checked for every override and auto-negotiation combination, both while the link is up and while it is down.

// File: rtl/lqm_pkg.sv
package lqm_pkg;
   typedef enum logic {
      LNK_DOWN = 1'b0,
      LNK_UP   = 1'b1
   } lnk_state_e;
endpackage

// File: rtl/lqm_lock_qual.sv
// Counts consecutive lock samples while armed; done is a combinational
// pulse on the edge that completes the qualification time.
module lqm_lock_qual #(
   parameter int QUAL_CYC = 5_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic lock_i,
   output logic done_o
);
   localparam int QW = (QUAL_CYC > 2) ? $clog2(QUAL_CYC) : 1;
   localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYC - 1);

   logic [QW-1:0] cnt_q;

   assign done_o = arm_i & lock_i & (cnt_q == Q_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!arm_i || !lock_i || done_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + QW'(1);
      end
   end
endmodule

// File: rtl/lqm_idle_watch.sv
// Tracks runs of consecutive idle symbols and the supervision window.
module lqm_idle_watch #(
   parameter int RUN_LEN = 16,
   parameter int WIN_CYC = 200_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic sym_vld_i,
   input  logic sym_idle_i,
   output logic run_done_o,
   output logic expire_o
);
   localparam int RW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
   localparam int WW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
   localparam logic [RW-1:0] R_LAST = RW'(RUN_LEN - 1);
   localparam logic [WW-1:0] W_LAST = WW'(WIN_CYC - 1);

   logic [RW-1:0] run_q;
   logic [WW-1:0] win_q;
   logic          idle_sym;
   logic          brk_sym;

   assign idle_sym   = sym_vld_i & sym_idle_i;
   assign brk_sym    = sym_vld_i & ~sym_idle_i;
   assign run_done_o = arm_i & idle_sym & (run_q == R_LAST);
   assign expire_o   = arm_i & (win_q == W_LAST) & ~run_done_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!arm_i || brk_sym || run_done_o) begin
         run_q <= '0;
      end else if (idle_sym) begin
         run_q <= run_q + RW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (!arm_i || run_done_o) begin
         win_q <= '0;
      end else if (win_q != W_LAST) begin
         win_q <= win_q + WW'(1);
      end
   end
endmodule

// File: rtl/lqm_tx_gate.sv
// Transmit permission and burst request; ALLOW_OVR selects whether the
// diagnostic override is built at all.
module lqm_tx_gate #(
   parameter bit ALLOW_OVR = 1'b1
) (
   input  logic link_i,
   input  logic an_en_i,
   input  logic ovr_i,
   output logic tx_allow_o,
   output logic burst_req_o
);
   assign burst_req_o = ~link_i & an_en_i;

   generate
      if (ALLOW_OVR) begin : g_ovr
         assign tx_allow_o = link_i | (ovr_i & ~an_en_i);
      end else begin : g_no_ovr
         logic unused_ovr;
         assign unused_ovr = ovr_i;
         assign tx_allow_o = link_i;
      end
   endgenerate
endmodule

// File: rtl/link_qual_mon.sv
module link_qual_mon
   import lqm_pkg::*;
#(
   parameter int QUAL_CYC  = 5_000_000,
   parameter int WIN_CYC   = 200_000,
   parameter int RUN_LEN   = 16,
   parameter bit ALLOW_OVR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_i,
   input  logic sym_vld_i,
   input  logic sym_idle_i,
   input  logic an_en_i,
   input  logic ovr_i,
   input  logic rd_stb_i,
   output logic link_o,
   output logic link_stat_o,
   output logic loss_irq_o,
   output logic rereq_o,
   output logic burst_req_o,
   output logic tx_allow_o
);
   generate
      if (QUAL_CYC < 2) begin : g_bad_qual
         $error("QUAL_CYC must be at least 2");
      end
      if (RUN_LEN < 2) begin : g_bad_run
         $error("RUN_LEN must be at least 2");
      end
      if (WIN_CYC <= RUN_LEN) begin : g_bad_win
         $error("WIN_CYC must exceed RUN_LEN");
      end
   endgenerate

   lnk_state_e st_q;
   logic       qual_done;
   logic       run_done;
   logic       expire;
   logic       is_up;
   logic       loss_evt;
   logic       irq_q;
   logic       rereq_q;
   logic       stat_q;

   assign is_up    = (st_q == LNK_UP);
   assign loss_evt = is_up & expire;

   lqm_lock_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (~is_up),
      .lock_i (lock_i),
      .done_o (qual_done)
   );

   lqm_idle_watch #(.RUN_LEN(RUN_LEN), .WIN_CYC(WIN_CYC)) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (is_up),
      .sym_vld_i  (sym_vld_i),
      .sym_idle_i (sym_idle_i),
      .run_done_o (run_done),
      .expire_o   (expire)
   );

   lqm_tx_gate #(.ALLOW_OVR(ALLOW_OVR)) u_gate (
      .link_i      (is_up),
      .an_en_i     (an_en_i),
      .ovr_i       (ovr_i),
      .tx_allow_o  (tx_allow_o),
      .burst_req_o (burst_req_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= LNK_DOWN;
      end else begin
         unique case (st_q)
            LNK_DOWN: if (qual_done) st_q <= LNK_UP;
            LNK_UP:   if (expire)    st_q <= LNK_DOWN;
            default:  st_q <= LNK_DOWN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q   <= 1'b0;
         rereq_q <= 1'b0;
         stat_q  <= 1'b0;
      end else begin
         irq_q   <= loss_evt;
         rereq_q <= loss_evt & an_en_i;
         if (loss_evt) begin
            stat_q <= 1'b0;
         end else if (rd_stb_i && is_up) begin
            stat_q <= 1'b1;
         end
      end
   end

   assign link_o      = is_up;
   assign link_stat_o = stat_q;
   assign loss_irq_o  = irq_q;
   assign rereq_o     = rereq_q;
endmodule

// File: rtl/lqm_chk.sv
module lqm_chk (
   input logic clk,
   input logic rst_n,
   input logic lock_i,
   input logic sym_vld_i,
   input logic sym_idle_i,
   input logic an_en_i,
   input logic ovr_i,
   input logic rd_stb_i,
   input logic link_o,
   input logic link_stat_o,
   input logic loss_irq_o,
   input logic rereq_o,
   input logic burst_req_o,
   input logic tx_allow_o
);
   // R1: the link only comes up on an edge where lock was sampled high
   a_r1_rise_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_o) |-> $past(lock_i));

   // R5: every loss of link raises the interrupt in the same cycle
   a_r5_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_o) |-> loss_irq_o);

   // R5: interrupt lasts a single cycle
   a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      loss_irq_o |=> !loss_irq_o);

   // R5: interrupt never while link is high
   a_r5_irq_link_low: assert property (@(posedge clk) disable iff (!rst_n)
      loss_irq_o |-> !link_o);

   // R6: renegotiation only alongside a loss with auto-negotiation on
   a_r6_rereq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      rereq_o |-> (loss_irq_o && $past(an_en_i)));

   // R7: latched bit can be set only while link holds
   a_r7_stat_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
      link_stat_o |-> link_o);

   // R7: latched bit rises only after a read strobe
   a_r7_stat_rise_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_stat_o) |-> $past(rd_stb_i));

   // R8: no transmit while down unless the override applies
   a_r8_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_o && (an_en_i || !ovr_i)) |-> !tx_allow_o);

   // R9: bursts only requested while down with auto-negotiation on
   a_r9_burst: assert property (@(posedge clk) disable iff (!rst_n)
      burst_req_o |-> (!link_o && an_en_i));

   // R10: a drop is never followed by an immediate return
   a_r10_no_bounce: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_o) |=> !link_o);
endmodule

bind link_qual_mon lqm_chk u_chk (.*);

// File: tb/link_qual_mon_test.sv
`timescale 1ns/1ps
module link_qual_mon_test;
   localparam int CLK_NS = 10;
   localparam int QC = 20;
   localparam int WC = 48;
   localparam int RL = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lock_i = 1'b0, sym_vld_i = 1'b0, sym_idle_i = 1'b0;
   logic an_en_i = 1'b1, ovr_i = 1'b0, rd_stb_i = 1'b0;
   logic link_o, link_stat_o, loss_irq_o, rereq_o, burst_req_o, tx_allow_o;

   int n_chk = 0;
   int n_bad = 0;
   int mode = 0;
   int ph = 0;

   always #(CLK_NS/2) clk = ~clk;

   link_qual_mon #(.QUAL_CYC(QC), .WIN_CYC(WC), .RUN_LEN(RL)) uut (
      .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .sym_vld_i(sym_vld_i),
      .sym_idle_i(sym_idle_i), .an_en_i(an_en_i), .ovr_i(ovr_i),
      .rd_stb_i(rd_stb_i), .link_o(link_o), .link_stat_o(link_stat_o),
      .loss_irq_o(loss_irq_o), .rereq_o(rereq_o),
      .burst_req_o(burst_req_o), .tx_allow_o(tx_allow_o));

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   // one cycle: wait for falling edge, then drive next symbol
   // mode 0 none, 1 all idle, 2 runs of RL-1, 3 runs of RL
   task automatic step();
      @(negedge clk);
      case (mode)
         1: begin sym_vld_i = 1'b1; sym_idle_i = 1'b1; end
         2: begin
            sym_vld_i = 1'b1; sym_idle_i = (ph != RL-1);
            ph = (ph + 1) % RL;
         end
         3: begin
            sym_vld_i = 1'b1; sym_idle_i = (ph != RL);
            ph = (ph + 1) % (RL + 1);
         end
         default: begin sym_vld_i = 1'b0; sym_idle_i = 1'b0; end
      endcase
   endtask

   // lock assumed high from the current negedge onward
   task automatic qualify(input string req);
      repeat (QC-1) step();
      chk({req, " link still low one edge short"}, link_o, 1'b0);
      step();
      chk({req, " link up after full qualification"}, link_o, 1'b1);
      chk("R5 no irq on rise", loss_irq_o, 1'b0);
   endtask

   task automatic hold_up(input string req, input int n);
      logic ok = 1'b1;
      for (int i = 0; i < n; i++) begin
         step();
         if (!link_o) ok = 1'b0;
      end
      chk({req, " link held"}, ok, 1'b1);
   endtask

   task automatic t_reset();
      chk("R11 link", link_o, 1'b0);
      chk("R11 stat", link_stat_o, 1'b0);
      chk("R11 irq", loss_irq_o, 1'b0);
      chk("R11 rereq", rereq_o, 1'b0);
      chk("R11 tx", tx_allow_o, 1'b0);
   endtask

   task automatic t_glitch_then_up();
      mode = 1;
      lock_i = 1'b1;
      repeat (QC-2) step();
      lock_i = 1'b0;
      step();
      chk("R2 no link after glitch", link_o, 1'b0);
      lock_i = 1'b1;
      qualify("R2 R1");
      hold_up("R3 idle stream", 3*WC);
      chk("R7 stat clear before read", link_stat_o, 1'b0);
      rd_stb_i = 1'b1;
      step();
      rd_stb_i = 1'b0;
      chk("R7 stat set by read", link_stat_o, 1'b1);
   endtask

   task automatic t_silent_drop();
      logic fell = 1'b0;
      mode = 0;
      an_en_i = 1'b1;
      for (int i = 0; i < 2*WC && !fell; i++) begin
         step();
         if (!link_o) fell = 1'b1;
      end
      chk("R4 drop without runs", link_o, 1'b0);
      chk("R5 irq at drop", loss_irq_o, 1'b1);
      chk("R6 rereq with autoneg", rereq_o, 1'b1);
      chk("R7 stat cleared on loss", link_stat_o, 1'b0);
      mode = 2;
      ph = 0;
      an_en_i = 1'b0;
      rd_stb_i = 1'b1;
      step();
      rd_stb_i = 1'b0;
      chk("R5 irq single cycle", loss_irq_o, 1'b0);
      chk("R6 rereq single cycle", rereq_o, 1'b0);
      step();
      chk("R7 read while down ignored", link_stat_o, 1'b0);
      // two edges of requalification already consumed
      repeat (QC-3) step();
      chk("R10 link low one edge short", link_o, 1'b0);
      step();
      chk("R10 requalified", link_o, 1'b1);
   endtask

   task automatic t_short_runs();
      repeat (WC-1) step();
      chk("R4 up one edge before window end", link_o, 1'b1);
      step();
      chk("R4 short runs drop link", link_o, 1'b0);
      chk("R5 irq on noisy drop", loss_irq_o, 1'b1);
      chk("R6 no rereq without autoneg", rereq_o, 1'b0);
      mode = 3;
      ph = 0;
      qualify("R10");
      hold_up("R3 exact runs", 3*WC);
   endtask

   task automatic t_gate();
      for (int k = 0; k < 4; k++) begin
         an_en_i = k[0]; ovr_i = k[1];
         step();
         chk("R8 tx while up", tx_allow_o, 1'b1);
         chk("R9 no burst while up", burst_req_o, 1'b0);
      end
      an_en_i = 1'b1; ovr_i = 1'b0;
      mode = 0;
      for (int i = 0; i < 2*WC && link_o; i++) step();
      lock_i = 1'b0;
      step();
      chk("R4 down for gate test", link_o, 1'b0);
      for (int k = 0; k < 4; k++) begin
         an_en_i = k[0]; ovr_i = k[1];
         step();
         chk("R8 tx while down", tx_allow_o, (k == 2));
         chk("R9 burst while down", burst_req_o, k[0]);
      end
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_glitch_then_up();
      t_silent_drop();
      t_short_runs();
      t_gate();
      report();
   end
endmodule